// File: doc/BRIEF.md
# Aliased Set/Clear/Masked Register Bridge

The bridge sits on a simple request/acknowledge bus in front of a small bank of 32-bit registers. Each register can be reached through several address windows. The window that an access falls in decides how a write changes the register:

- **Plain** writes replace the strobed bytes.
- **Set** writes OR bits in.
- **Clear** writes drop bits.
- **Masked** writes carry both a mask and a field value in one operand. There are three masked windows, for 4-, 8- and 16-bit fields. Only the masked bits take the new value.

Software can therefore change a field with one bus write instead of a read-modify-write sequence of its own.

A write is turned into a read-modify-write of the target register inside the block and commits at the accepting clock edge. A read returns the whole register word, whichever register window it uses.

A one-bit configuration register can make write acknowledgements wait for a fixed commit latency. This models a slower slave behind the bridge. While such a write is pending, the bridge is busy and drops new requests.

Top module: `alias_reg_bridge`

## Requirements
- R1: Plain window (byte offset 0x000, 4 bytes per register, register k at 4k): a write replaces exactly the bytes whose strobe bit is set. Strobe bit n carries data bits [8n+7:8n]. Reads return the full 32-bit register word.
- R2: Set window (0x080, 4 bytes per register): every write-data bit that is 1 under an active strobe becomes 1 in the register. All other bits keep their value.
- R3: Clear window (0x100, 4 bytes per register): every write-data bit that is 1 under an active strobe becomes 0 in the register. This holds for byte and word operands alike.
- R4: 16-bit masked window (0x400, 8 bytes per register, register k at 8k): a 32-bit write carries the mask in bits [31:16] and the value in bits [15:0]. At offset 0 it updates register bits [15:0], and only the bits whose mask bit is 1.
- R5: In the 16-bit masked window, offset 8k+4 applies the same mask/value rule to bits [31:16] of register k.
- R6: 8-bit masked window (0x300, 8 bytes per register): a 16-bit write at offset 8k+2j carries the mask in its upper byte and the value in its lower byte. It updates byte j of register k under that mask.
- R7: 4-bit masked window (0x200, 8 bytes per register): an 8-bit write at offset 8k+j carries the mask in bits [7:4] and the value in bits [3:0]. It updates nibble j (bits [4j+3:4j]) of register k under that mask.
- R8: The following writes leave every register unchanged:
  - a masked-window write whose size is not that window's operand size;
  - a write whose strobe pattern is not one of 0001, 0010, 0100, 1000, 0011, 1100, 1111;
  - a write whose register index is at or above NREG (no index wrap).
- R9: A write commits at the edge that accepts it, so a read accepted on the next edge returns the new value. Without wait mode, `bus_ack` is high in the cycle after each accepted access, and one access per cycle is accepted.
- R10: The configuration word sits at 0x500, and bit 0 enables wait mode. With wait mode on, a write's `bus_ack` rises COMMIT_LAT cycles after acceptance, with `bus_busy` high meanwhile. Requests seen while busy are dropped. Reads and configuration writes still take one cycle.
- R11: Reads in the set, clear and masked windows return the addressed register word. Reads of an out-of-range index or an unmapped address return 0.
- R12: After reset:
  - every register and the configuration word are 0;
  - `bus_ack` and `bus_busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] are ignored, and the lane comes from the strobes |
| bus_be | input | 4 | Byte strobes; strobe n enables data bits [8n+7:8n] |
| bus_wdata | input | 32 | Write data, placed on its byte lanes |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Access completed |
| bus_busy | output | 1 | A waited write is pending; requests are dropped |

## Verification
A vector table drives every window with operands that differ by operand size, lane and partial masks. The masks used include 0x0F in the 8-bit window and 0x3 in the 4-bit window, so a design that ignores the mask or takes the value from the wrong half shows up.

Each write is followed by a read-back through the plain window. A misplaced field position, a missing lane shift or a swapped mask/value half each yields a different register word.

Size-mismatched, badly strobed and out-of-range writes are aimed at registers that already hold known data. The out-of-range write uses index 9, so a truncated index would corrupt register 1.

Directed sequences cover:
- back-to-back write then read;
- reads through the alias windows;
- wait mode, with a request dropped while busy.

// File: rtl/alias_bridge_pkg.sv
package alias_bridge_pkg;

  localparam int DW     = 32;
  localparam int SLOT_W = 5;

  // Window bases (byte offsets) and spans
  localparam int B_PLAIN = 'h000;
  localparam int B_SET   = 'h080;
  localparam int B_CLR   = 'h100;
  localparam int B_M4    = 'h200;
  localparam int B_M8    = 'h300;
  localparam int B_M16   = 'h400;
  localparam int B_CFG   = 'h500;
  localparam int SPAN_W  = 'h080;
  localparam int SPAN_M  = 'h100;

  typedef enum logic [2:0] {
    W_PLAIN, W_SET, W_CLR, W_M4, W_M8, W_M16, W_CFG, W_NONE
  } win_e;

  // Field rule: bits allowed to change and the value they take
  typedef struct packed {
    logic [DW-1:0] fmask;
    logic [DW-1:0] fval;
  } rule_t;

  function automatic logic be_legal(input logic [3:0] be);
    case (be)
      4'b0001, 4'b0010, 4'b0100, 4'b1000,
      4'b0011, 4'b1100, 4'b1111: be_legal = 1'b1;
      default:                   be_legal = 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] be_lane(input logic [3:0] be);
    if (be[0])      be_lane = 2'd0;
    else if (be[1]) be_lane = 2'd1;
    else if (be[2]) be_lane = 2'd2;
    else            be_lane = 2'd3;
  endfunction

  function automatic logic [2:0] be_bytes(input logic [3:0] be);
    be_bytes = 3'(be[0]) + 3'(be[1]) + 3'(be[2]) + 3'(be[3]);
  endfunction

  function automatic logic [DW-1:0] be_mask(input logic [3:0] be);
    be_mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic rule_t field_rule(input win_e w, input logic [2:0] sub,
                                       input logic [3:0] be, input logic [DW-1:0] wd);
    logic [DW-1:0] bm;
    logic [DW-1:0] lane_op;
    logic [15:0]   h;
    logic [7:0]    b;
    rule_t r;
    bm      = be_mask(be);
    lane_op = wd >> {be_lane(be), 3'b000};
    h       = lane_op[15:0];
    b       = lane_op[7:0];
    r       = '0;
    case (w)
      W_PLAIN: begin r.fmask = bm;      r.fval = wd;      end
      W_SET:   begin r.fmask = wd & bm; r.fval = '1;      end
      W_CLR:   begin r.fmask = wd & bm; r.fval = '0;      end
      W_M16: begin
        r.fmask = sub[0] ? {wd[31:16], 16'h0} : {16'h0, wd[31:16]};
        r.fval  = sub[0] ? {wd[15:0], 16'h0}  : {16'h0, wd[15:0]};
      end
      W_M8: begin
        r.fmask = DW'(h[15:8]) << {sub[1:0], 3'b000};
        r.fval  = DW'(h[7:0])  << {sub[1:0], 3'b000};
      end
      W_M4: begin
        r.fmask = DW'(b[7:4]) << {sub, 2'b00};
        r.fval  = DW'(b[3:0]) << {sub, 2'b00};
      end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/abr_decode.sv
module abr_decode
  import alias_bridge_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int NREG   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output win_e              win,
  output logic [SLOT_W-1:0] slot,
  output logic [2:0]        sub,
  output logic              be_ok,
  output logic              size_ok,
  output logic              in_range
);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] lo;
  logic [2:0]        nbytes;

  assign off    = {addr[ADDR_W-1:2], be_lane(be)};
  assign be_ok  = be_legal(be);
  assign nbytes = be_bytes(be);

  always_comb begin
    win = W_NONE;
    lo  = '0;
    if (off < ADDR_W'(B_PLAIN + SPAN_W)) begin
      win = W_PLAIN; lo = off - ADDR_W'(B_PLAIN);
    end else if (off >= ADDR_W'(B_SET) && off < ADDR_W'(B_SET + SPAN_W)) begin
      win = W_SET;   lo = off - ADDR_W'(B_SET);
    end else if (off >= ADDR_W'(B_CLR) && off < ADDR_W'(B_CLR + SPAN_W)) begin
      win = W_CLR;   lo = off - ADDR_W'(B_CLR);
    end else if (off >= ADDR_W'(B_M4) && off < ADDR_W'(B_M4 + SPAN_M)) begin
      win = W_M4;    lo = off - ADDR_W'(B_M4);
    end else if (off >= ADDR_W'(B_M8) && off < ADDR_W'(B_M8 + SPAN_M)) begin
      win = W_M8;    lo = off - ADDR_W'(B_M8);
    end else if (off >= ADDR_W'(B_M16) && off < ADDR_W'(B_M16 + SPAN_M)) begin
      win = W_M16;   lo = off - ADDR_W'(B_M16);
    end else if (off[ADDR_W-1:2] == (ADDR_W-2)'(B_CFG >> 2)) begin
      win = W_CFG;
    end
  end

  // Word-dense windows use 4 bytes per slot, masked windows 8
  always_comb begin
    slot = '0;
    sub  = '0;
    case (win)
      W_PLAIN, W_SET, W_CLR: slot = lo[6:2];
      W_M4:  begin slot = lo[7:3]; sub = lo[2:0];          end
      W_M8:  begin slot = lo[7:3]; sub = {1'b0, lo[2:1]};  end
      W_M16: begin slot = lo[7:3]; sub = {2'b00, lo[2]};   end
      default: ;
    endcase
  end

  always_comb begin
    case (win)
      W_M4:    size_ok = (nbytes == 3'd1);
      W_M8:    size_ok = (nbytes == 3'd2);
      W_M16:   size_ok = (nbytes == 3'd4);
      default: size_ok = 1'b1;
    endcase
  end

  assign in_range = ({1'b0, slot} < (SLOT_W+1)'(NREG));

endmodule

// File: rtl/abr_regfile.sv
module abr_regfile
  import alias_bridge_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [SLOT_W-1:0] rd_idx,
  output logic [DW-1:0]     rd_data
);

  localparam int RIW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [NREG-1:0][DW-1:0] flat;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= '0;
      else if (wr_en && wr_idx == SLOT_W'(g))    q <= wr_data;
    end
    assign flat[g] = q;
  end

  logic [RIW-1:0] rd_sel;
  assign rd_sel  = rd_idx[RIW-1:0];
  assign rd_data = ({1'b0, rd_idx} < (SLOT_W+1)'(NREG)) ? flat[rd_sel] : '0;

endmodule

// File: rtl/abr_resp.sv
module abr_resp #(
  parameter int COMMIT_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic waited,
  output logic ack,
  output logic busy
);

  localparam int CW = $clog2(COMMIT_LAT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ack <= 1'b0;
    end else if (fire) begin
      if (waited && COMMIT_LAT > 1) begin
        cnt <= CW'(COMMIT_LAT - 1);
        ack <= 1'b0;
      end else begin
        ack <= 1'b1;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      ack <= (cnt == CW'(1));
    end else begin
      ack <= 1'b0;
    end
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/alias_reg_bridge.sv
module alias_reg_bridge
  import alias_bridge_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int NREG       = 8,
  parameter int COMMIT_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_ack,
  output logic              bus_busy
);

  win_e              win;
  logic [SLOT_W-1:0] slot;
  logic [2:0]        sub;
  logic              be_ok, size_ok, in_range;

  abr_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .addr(bus_addr), .be(bus_be), .win(win), .slot(slot), .sub(sub),
    .be_ok(be_ok), .size_ok(size_ok), .in_range(in_range)
  );

  logic reg_win;
  assign reg_win = (win != W_CFG) && (win != W_NONE);

  // Named events for the checker
  logic          acc_fire, acc_waited, upd_en;
  logic [DW-1:0] upd_old, upd_new, upd_fmask;
  rule_t         rule;
  logic          wait_en;

  assign acc_fire   = bus_req && !bus_busy;
  assign acc_waited = bus_we && wait_en && (win != W_CFG);
  assign upd_en     = acc_fire && bus_we && reg_win && be_ok && size_ok && in_range;

  abr_regfile #(.NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(upd_en), .wr_idx(slot), .wr_data(upd_new),
    .rd_idx(slot), .rd_data(upd_old)
  );

  assign rule      = field_rule(win, sub, bus_be, bus_wdata);
  assign upd_fmask = rule.fmask;
  assign upd_new   = (upd_old & ~rule.fmask) | (rule.fval & rule.fmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wait_en <= 1'b0;
    else if (acc_fire && bus_we && win == W_CFG && bus_be[0])
      wait_en <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (acc_fire) begin
      if (bus_we)                  bus_rdata <= '0;
      else if (win == W_CFG)       bus_rdata <= DW'(wait_en);
      else if (reg_win && in_range) bus_rdata <= upd_old;
      else                         bus_rdata <= '0;
    end
  end

  abr_resp #(.COMMIT_LAT(COMMIT_LAT)) u_resp (
    .clk(clk), .rst_n(rst_n), .fire(acc_fire), .waited(acc_waited),
    .ack(bus_ack), .busy(bus_busy)
  );

endmodule

// File: rtl/abr_checker.sv
module abr_checker
  import alias_bridge_pkg::*;
#(
  parameter int COMMIT_LAT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_fire,
  input logic          acc_waited,
  input logic          upd_en,
  input win_e          upd_win,
  input logic [DW-1:0] upd_old,
  input logic [DW-1:0] upd_new,
  input logic [DW-1:0] upd_fmask,
  input logic          bus_we,
  input logic          size_ok,
  input logic          bus_ack,
  input logic          bus_busy
);

  a_r9_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !acc_waited |=> bus_ack);

  a_r10_hold_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (COMMIT_LAT > 1) && acc_fire && acc_waited |=> bus_busy && !bus_ack);

  a_r10_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !acc_fire);

  a_r2_set_only_raises: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_win == W_SET |-> (upd_old & ~upd_new) == '0);

  a_r3_clear_only_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_win == W_CLR |-> (upd_new & ~upd_old) == '0);

  a_r4_field_confined: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> ((upd_new ^ upd_old) & ~upd_fmask) == '0);

  a_r8_mismatch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && bus_we && !size_ok |-> !upd_en);

endmodule

bind alias_reg_bridge abr_checker #(.COMMIT_LAT(COMMIT_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .acc_waited(acc_waited),
  .upd_en(upd_en), .upd_win(win), .upd_old(upd_old), .upd_new(upd_new),
  .upd_fmask(upd_fmask), .bus_we(bus_we), .size_ok(size_ok),
  .bus_ack(bus_ack), .bus_busy(bus_busy)
);

// File: tb/tb_alias_reg_bridge.sv
module tb_alias_reg_bridge;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack, bus_busy;

  int total = 0, bad = 0, cycles = 0;

  always #4 clk = ~clk;

  alias_reg_bridge #(.ADDR_W(11), .NREG(8), .COMMIT_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_busy(bus_busy)
  );

  typedef struct packed {
    logic [10:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [2:0]  ridx;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{11'h004, 4'hF, 32'h12345678, 3'd1, 32'h12345678, 4'd1},  // R1 word
    '{11'h004, 4'h4, 32'h00AB0000, 3'd1, 32'h12AB5678, 4'd1},  // R1 byte 2
    '{11'h004, 4'hC, 32'hCDEF0000, 3'd1, 32'hCDEF5678, 4'd1},  // R1 high half
    '{11'h084, 4'hF, 32'h000000F0, 3'd1, 32'hCDEF56F8, 4'd2},  // R2 word
    '{11'h104, 4'hF, 32'hFF000000, 3'd1, 32'h00EF56F8, 4'd3},  // R3 word
    '{11'h104, 4'h2, 32'h00005600, 3'd1, 32'h00EF00F8, 4'd3},  // R3 byte
    '{11'h084, 4'h8, 32'h81000000, 3'd1, 32'h81EF00F8, 4'd2},  // R2 byte
    '{11'h410, 4'hF, 32'hFFFF5555, 3'd2, 32'h00005555, 4'd4},  // R4
    '{11'h414, 4'hF, 32'h01FF01AA, 3'd2, 32'h01AA5555, 4'd5},  // R5
    '{11'h318, 4'hC, 32'hFF110000, 3'd3, 32'h00001100, 4'd6},  // R6 byte1
    '{11'h31C, 4'hC, 32'hFF330000, 3'd3, 32'h33001100, 4'd6},  // R6 byte3
    '{11'h318, 4'h3, 32'h00000FA5, 3'd3, 32'h33001105, 4'd6},  // R6 partial
    '{11'h220, 4'h1, 32'h000000F7, 3'd4, 32'h00000007, 4'd7},  // R7 nib0
    '{11'h224, 4'h2, 32'h0000F400, 3'd4, 32'h00400007, 4'd7},  // R7 nib5
    '{11'h220, 4'h2, 32'h00003F00, 3'd4, 32'h00400037, 4'd7},  // R7 partial
    '{11'h410, 4'h3, 32'h0000FF00, 3'd2, 32'h01AA5555, 4'd8},  // R8 m16 size
    '{11'h318, 4'hF, 32'hFFFFFFFF, 3'd3, 32'h33001105, 4'd8},  // R8 m8 size
    '{11'h220, 4'h3, 32'h0000FFFF, 3'd4, 32'h00400037, 4'd8},  // R8 m4 size
    '{11'h004, 4'h5, 32'hFFFFFFFF, 3'd1, 32'h81EF00F8, 4'd8},  // R8 strobes
    '{11'h024, 4'hF, 32'hFFFFFFFF, 3'd1, 32'h81EF00F8, 4'd8}   // R8 index 9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [10:0] a, input logic [3:0] be,
                     input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
    @(negedge clk);
    bus_req = 1'b0;
    lat = 1;
    while (!bus_ack && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rd = bus_rdata;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL R9 watchdog actual=timeout expected=ack");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 ack", 32'(bus_ack), 32'd0);
    chk("R12 busy", 32'(bus_busy), 32'd0);
    rst_n = 1'b1;
    acc(1'b0, 11'h000, 4'hF, '0, rd, lat); chk("R12 reg0", rd, 32'h0);
    acc(1'b0, 11'h500, 4'hF, '0, rd, lat); chk("R12 cfg", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      acc(1'b1, VECS[i].addr, VECS[i].be, VECS[i].wd, rd, lat);
      acc(1'b0, 11'({VECS[i].ridx, 2'b00}), 4'hF, '0, rd, lat);
      chk($sformatf("R%0d vec%0d", VECS[i].rq, i), rd, VECS[i].exp);
    end

    // R9 back-to-back write then read
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 11'h000; bus_be = 4'hF; bus_wdata = 32'hA5A50F0F;
    @(negedge clk);
    chk("R9 ack after write", 32'(bus_ack), 32'd1);
    bus_we = 1'b0;
    @(negedge clk);
    chk("R9 ack after read", 32'(bus_ack), 32'd1);
    chk("R9 read next cycle", bus_rdata, 32'hA5A50F0F);
    bus_req = 1'b0;

    // R11 alias-window reads
    acc(1'b0, 11'h084, 4'hF, '0, rd, lat); chk("R11 set window", rd, 32'h81EF00F8);
    acc(1'b0, 11'h104, 4'h1, '0, rd, lat); chk("R11 clear window", rd, 32'h81EF00F8);
    acc(1'b0, 11'h410, 4'hF, '0, rd, lat); chk("R11 m16 window", rd, 32'h01AA5555);
    acc(1'b0, 11'h31C, 4'hC, '0, rd, lat); chk("R11 m8 window", rd, 32'h33001105);
    acc(1'b0, 11'h024, 4'hF, '0, rd, lat); chk("R11 out of range", rd, 32'h0);
    acc(1'b0, 11'h600, 4'hF, '0, rd, lat); chk("R11 unmapped", rd, 32'h0);

    // R10 wait mode
    acc(1'b1, 11'h500, 4'h1, 32'h1, rd, lat); chk("R10 cfg write latency", 32'(lat), 32'd1);
    acc(1'b0, 11'h500, 4'hF, '0, rd, lat); chk("R10 cfg readback", rd, 32'h1);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 11'h014; bus_be = 4'hF; bus_wdata = 32'hCAFE0001;
    @(negedge clk);
    bus_req = 1'b0;
    chk("R10 busy", 32'(bus_busy), 32'd1);
    chk("R10 ack held", 32'(bus_ack), 32'd0);
    lat = 1;
    @(negedge clk); lat++;
    bus_req = 1'b1; bus_addr = 11'h018; bus_wdata = 32'hFFFFFFFF;
    @(negedge clk); lat++;
    bus_req = 1'b0;
    while (!bus_ack && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 waited latency", 32'(lat), 32'(LAT));
    acc(1'b0, 11'h014, 4'hF, '0, rd, lat); chk("R10 waited write landed", rd, 32'hCAFE0001);
    chk("R10 read latency", 32'(lat), 32'd1);
    acc(1'b0, 11'h018, 4'hF, '0, rd, lat); chk("R10 dropped while busy", rd, 32'h0);
    acc(1'b1, 11'h500, 4'h1, 32'h0, rd, lat);
    acc(1'b1, 11'h01C, 4'hF, 32'h1, rd, lat); chk("R10 wait off latency", 32'(lat), 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule